// File: doc/BRIEF.md
# Prioritized Wake-Up Controller

This always-on controller watches a set of wake sources while the main processor sleeps. The sources are a group of general-purpose pins, a periodic timer tick, a communication-activity strobe and a threshold-crossing flag. Every source first passes a two-stage synchronizer and then a debounce filter that needs a programmable hold time. After that, a per-source enable and an edge-or-level choice decide whether the source registers an event.

Each event is one of two kinds. A direct event raises the wake request at once. A qualifying event only advances a counter, and the processor is woken when that counter reaches a programmed count. Until then the controller keeps waiting. Each source can be marked urgent. An urgent source always wakes directly and asks for the full-performance operating point. Routine sources ask for the low-power point. The sources that caused the wake are latched in a cause vector, which the processor clears by writing ones.

Top module: `wake_prio_ctrl`

## Requirements
- R1: After reset, `wake_req_o`, `wake_perf_o` and every bit of `cause_o` are 0.
- R2: A raw source level counts only after it has been seen through the two-flop synchronizer on `deb_len_i` consecutive cycles (a value of 0 acts as 1). A pulse sampled on fewer cycles never triggers. A rising input first sampled high on clock edge k makes `wake_req_o` high after edge k+`deb_len_i`+2, and not earlier.
- R3: A source whose `src_en_i` bit is 0 neither sets a cause bit nor raises the wake request.
- R4: A source with `src_lvl_i` = 0 triggers only on a rising filtered edge. With `src_lvl_i` = 1 it triggers on every cycle its filtered value is high, so a held source wakes again each time the controller goes back to waiting.
- R5: The bit positions in the source vector and in `cause_o` are: gpio bits [NGPIO-1:0], tick at NGPIO, comm at NGPIO+1, threshold flag at NGPIO+2. Every source that triggers in the cycle the wake fires is recorded, including several sources in the same cycle.
- R6: When `clr_we_i` is high, each `cause_o` bit with a 1 in `clr_data_i` clears on the next edge. Bits written with 0 keep their value.
- R7: `wake_perf_o` is set to 1 (full performance) when any urgent source is among the causes of a wake, and to 0 (low power) when all the causes are routine.
- R8: A non-urgent source with `src_qual_i` = 1 does not wake directly. Each cycle with at least one such event increments a counter. The wake fires on the event that brings the counter to `qual_thr_i` (0 acts as 1), and the sources of that event are recorded as the cause.
- R9: An urgent source wakes directly even when its `src_qual_i` bit is 1.
- R10: Events are only acted on while `sleep_i` is 1 and no request is pending. `wake_req_o` stays high until `sleep_i` goes to 0 and drops on the following edge.
- R11: The qualification counter returns to 0 when a wake fires and whenever `sleep_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Processor is asleep; controller may wake it |
| gpio_i | input | NGPIO | Raw wake pins |
| tick_i | input | 1 | Periodic timer tick |
| comm_i | input | 1 | Communication activity strobe |
| thr_i | input | 1 | Threshold-crossing flag |
| src_en_i | input | NGPIO+3 | Per-source enable |
| src_lvl_i | input | NGPIO+3 | 1 = level trigger, 0 = rising edge |
| src_urg_i | input | NGPIO+3 | 1 = urgent (full-performance target) |
| src_qual_i | input | NGPIO+3 | 1 = source goes through the count qualification |
| deb_len_i | input | DEB_W | Debounce hold length in cycles |
| qual_thr_i | input | QW | Qualifying events needed to wake |
| clr_we_i | input | 1 | Cause clear strobe |
| clr_data_i | input | NGPIO+3 | Write-one-to-clear mask for the cause |
| wake_req_o | output | 1 | Wake request to the processor |
| wake_perf_o | output | 1 | Target: 1 full performance, 0 low power |
| cause_o | output | NGPIO+3 | Latched wake causes |

## Verification
The filter is tested in two ways: with a glitch one cycle shorter than the hold time and with a sustained level, which separates correct filtering from a stuck or missing filter and pins down the exact cycle of the wake. Pairs of sources fired together, one routine and one urgent, show whether all causes are recorded and whether the higher target wins. Runs of tick pulses under qualification, with a return to the awake state between runs, show whether wakes come on the Nth event and whether the counter is reset. A source held high in level mode and then in edge mode shows whether re-arming repeats the wake or not.

// File: rtl/wake_prio_ctrl.sv
module wake_prio_ctrl #(
  parameter int NGPIO = 4,
  parameter int DEB_W = 4,
  parameter int QW    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_i,
  input  logic [NGPIO-1:0]   gpio_i,
  input  logic               tick_i,
  input  logic               comm_i,
  input  logic               thr_i,
  input  logic [NGPIO+2:0]   src_en_i,
  input  logic [NGPIO+2:0]   src_lvl_i,
  input  logic [NGPIO+2:0]   src_urg_i,
  input  logic [NGPIO+2:0]   src_qual_i,
  input  logic [DEB_W-1:0]   deb_len_i,
  input  logic [QW-1:0]      qual_thr_i,
  input  logic               clr_we_i,
  input  logic [NGPIO+2:0]   clr_data_i,
  output logic               wake_req_o,
  output logic               wake_perf_o,
  output logic [NGPIO+2:0]   cause_o
);
  localparam int NSRC = NGPIO + 3;

  logic [NSRC-1:0]  raw, s1, s2, filt, filt_d;
  logic [NSRC-1:0]  hit, direct, qhit, wset;
  logic [DEB_W-1:0] deb_eff;
  logic [QW-1:0]    thr_eff, qcnt;
  logic             armed, qev, qdone, fire;

  assign raw     = {thr_i, comm_i, tick_i, gpio_i};
  assign deb_eff = (deb_len_i == '0) ? DEB_W'(1) : deb_len_i;
  assign thr_eff = (qual_thr_i == '0) ? QW'(1) : qual_thr_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1     <= '0;
      s2     <= '0;
      filt_d <= '0;
    end else begin
      s1     <= raw;
      s2     <= s1;
      filt_d <= filt;
    end

  for (genvar i = 0; i < NSRC; i++) begin : g_deb
    logic [DEB_W-1:0] cnt;
    logic             f;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt <= '0;
        f   <= 1'b0;
      end else if (s2[i] == f) begin
        cnt <= '0;
      end else if (cnt == deb_eff - 1'b1) begin
        cnt <= '0;
        f   <= s2[i];
      end else begin
        cnt <= cnt + 1'b1;
      end
    assign filt[i] = f;
  end

  assign hit    = src_en_i & ((src_lvl_i & filt) | (~src_lvl_i & filt & ~filt_d));
  assign direct = hit & (~src_qual_i | src_urg_i);
  assign qhit   = hit & src_qual_i & ~src_urg_i;
  assign armed  = sleep_i & ~wake_req_o;
  assign qev    = |qhit;
  assign qdone  = qev && (({1'b0, qcnt} + 1'b1) >= {1'b0, thr_eff});
  assign fire   = armed & ((|direct) | qdone);
  assign wset   = direct | (qdone ? qhit : '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wake_req_o  <= 1'b0;
      wake_perf_o <= 1'b0;
      cause_o     <= '0;
      qcnt        <= '0;
    end else begin
      cause_o <= (cause_o & ~(clr_we_i ? clr_data_i : '0)) | (fire ? wset : '0);
      if (!sleep_i) begin
        wake_req_o <= 1'b0;
        qcnt       <= '0;
      end else if (fire) begin
        wake_req_o  <= 1'b1;
        wake_perf_o <= |(wset & src_urg_i);
        qcnt        <= '0;
      end else if (armed && qev) begin
        qcnt <= qcnt + 1'b1;
      end
    end
endmodule

// File: rtl/wake_prio_ctrl_chk.sv
module wake_prio_ctrl_chk #(
  parameter int NGPIO = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep_i,
  input logic [NGPIO+2:0] src_en_i,
  input logic [NGPIO+2:0] src_urg_i,
  input logic             clr_we_i,
  input logic [NGPIO+2:0] clr_data_i,
  input logic             wake_req_o,
  input logic             wake_perf_o,
  input logic [NGPIO+2:0] cause_o
);
  // R10
  awake_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_i |=> !wake_req_o);

  // R10
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req_o && sleep_i) |=> wake_req_o);

  // R5
  cause_only_on_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_o & ~$past(cause_o)) != '0) |-> $rose(wake_req_o));

  // R3
  disabled_never_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_o & ~$past(cause_o) & ~$past(src_en_i)) == '0));

  // R7
  urgent_full_perf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wake_req_o) && ((cause_o & ~$past(cause_o) & $past(src_urg_i)) != '0)) |-> wake_perf_o);

  // R6
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && sleep_i && wake_req_o) |=> ((cause_o & $past(clr_data_i)) == '0));
endmodule

bind wake_prio_ctrl wake_prio_ctrl_chk #(.NGPIO(NGPIO)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .src_en_i(src_en_i),
  .src_urg_i(src_urg_i), .clr_we_i(clr_we_i), .clr_data_i(clr_data_i),
  .wake_req_o(wake_req_o), .wake_perf_o(wake_perf_o), .cause_o(cause_o)
);

// File: tb/wake_prio_ctrl_bench.sv
module wake_prio_ctrl_bench;
  localparam int NG = 4;
  localparam int NS = NG + 3;
  localparam int DL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep = 1'b0;
  logic [NS-1:0] s = '0, en = '1, lvl = '0, urg = '0, qm = '0;
  logic [3:0] deb = 4'(DL), qthr = 4'd1;
  logic clr_we = 1'b0;
  logic [NS-1:0] clr_data = '0;
  logic wake_req, wake_perf;
  logic [NS-1:0] cause;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  wake_prio_ctrl #(.NGPIO(NG), .DEB_W(4), .QW(4)) u_wake_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep), .gpio_i(s[NG-1:0]),
    .tick_i(s[NG]), .comm_i(s[NG+1]), .thr_i(s[NG+2]),
    .src_en_i(en), .src_lvl_i(lvl), .src_urg_i(urg), .src_qual_i(qm),
    .deb_len_i(deb), .qual_thr_i(qthr), .clr_we_i(clr_we), .clr_data_i(clr_data),
    .wake_req_o(wake_req), .wake_perf_o(wake_perf), .cause_o(cause)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  task automatic hold(input logic [NS-1:0] m, input int n);
    @(negedge clk);
    s = s | m;
    repeat (n) @(negedge clk);
    s = s & ~m;
    settle();
  endtask

  task automatic ack();
    @(negedge clk);
    sleep = 1'b0; clr_we = 1'b1; clr_data = '1;
    @(negedge clk);
    clr_we = 1'b0; clr_data = '0; sleep = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 wake_req", wake_req, 0);
    chk("R1 wake_perf", wake_perf, 0);
    chk("R1 cause", cause, 0);
  endtask

  task automatic t_debounce();
    sleep = 1'b1;
    hold(7'b0000001, DL - 1);
    chk("R2 glitch ignored req", wake_req, 0);
    chk("R2 glitch ignored cause", cause, 0);
    @(negedge clk);
    s[0] = 1'b1;
    repeat (DL + 2) @(negedge clk);
    chk("R2 not before hold", wake_req, 0);
    @(negedge clk);
    chk("R2 wake on time", wake_req, 1);
    chk("R5 gpio0 bit", cause, 7'b0000001);
    s[0] = 1'b0;
    settle();
    ack();
  endtask

  task automatic t_disable();
    en[1] = 1'b0;
    hold(7'b0000010, 6);
    chk("R3 disabled req", wake_req, 0);
    chk("R3 disabled cause", cause, 0);
    en[1] = 1'b1;
    ack();
  endtask

  task automatic t_multi_w1c();
    hold(7'b0100100, 6);
    chk("R5 two causes", cause, 7'b0100100);
    chk("R7 routine perf", wake_perf, 0);
    @(negedge clk);
    clr_we = 1'b1; clr_data = 7'b0000100;
    @(negedge clk);
    clr_we = 1'b0; clr_data = '0;
    chk("R6 w1c partial", cause, 7'b0100000);
    chk("R10 req held", wake_req, 1);
    ack();
    chk("R10 ack clears req", wake_req, 0);
  endtask

  task automatic t_priority();
    urg[6] = 1'b1;
    hold(7'b1000000, 6);
    chk("R7 urgent perf", wake_perf, 1);
    chk("R5 thr bit", cause, 7'b1000000);
    ack();
    hold(7'b1001000, 6);
    chk("R7 mixed perf", wake_perf, 1);
    chk("R5 mixed causes", cause, 7'b1001000);
    ack();
    hold(7'b0001000, 6);
    chk("R7 routine after urgent", wake_perf, 0);
    ack();
    urg[6] = 1'b0;
  endtask

  task automatic t_qualify();
    qm[4] = 1'b1; qthr = 4'd3;
    hold(7'b0010000, 4);
    hold(7'b0010000, 4);
    chk("R8 two events no wake", wake_req, 0);
    chk("R8 two events no cause", cause, 0);
    hold(7'b0010000, 4);
    chk("R8 third event wakes", wake_req, 1);
    chk("R8 tick cause", cause, 7'b0010000);
    ack();
    hold(7'b0010000, 4);
    hold(7'b0010000, 4);
    ack();
    hold(7'b0010000, 4);
    hold(7'b0010000, 4);
    chk("R11 counter reset by awake", wake_req, 0);
    hold(7'b0010000, 4);
    chk("R11 wake after fresh count", wake_req, 1);
    ack();
    qm[4] = 1'b0; qthr = 4'd1;
  endtask

  task automatic t_urgent_bypass();
    qm[6] = 1'b1; urg[6] = 1'b1; qthr = 4'd5;
    hold(7'b1000000, 6);
    chk("R9 urgent bypass", wake_req, 1);
    chk("R9 urgent perf", wake_perf, 1);
    ack();
    qm[6] = 1'b0; urg[6] = 1'b0; qthr = 4'd1;
  endtask

  task automatic t_edge_level();
    lvl[0] = 1'b1;
    @(negedge clk);
    s[0] = 1'b1;
    settle();
    chk("R4 level wake", wake_req, 1);
    ack();
    repeat (3) @(negedge clk);
    chk("R4 level rewakes", wake_req, 1);
    chk("R4 level cause", cause, 7'b0000001);
    lvl[0] = 1'b0;
    ack();
    settle();
    chk("R4 edge no rewake", wake_req, 0);
    s[0] = 1'b0;
    settle();
  endtask

  task automatic t_awake_ignore();
    sleep = 1'b0;
    hold(7'b0000100, 6);
    chk("R10 awake no req", wake_req, 0);
    chk("R10 awake no cause", cause, 0);
    sleep = 1'b1;
    settle();
    chk("R10 stale edge ignored", wake_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_debounce();
    t_disable();
    t_multi_w1c();
    t_priority();
    t_qualify();
    t_urgent_bypass();
    t_edge_level();
    t_awake_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule